// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is a single programmable logic element of the kind tiled across a reconfigurable array. It holds two 8-entry truth tables addressed by the same three selected inputs, so one cell yields two independent 3-input functions at once. A mode bit instead fuses the two tables into one 16-entry table, with the fourth operand picking between them. A front-end AND gate on the first table input forms a bit product for array multipliers. A mode bit steers the carry input onto the third table input. Another mode bit replaces an operand with the cell's own flip-flop output, which lets one cell hold a counter bit or an accumulating sum.

The flip-flop captures the main result on the rising clock edge. Its asynchronous, active-low set/reset line forces it to 1 or 0, chosen by a mode bit. The main output is taken either straight from the tables or from the flip-flop. It is also driven onto a bus pin that floats unless the output enable is high.

Configuration arrives as writes on a small valid/ready port. The cell never applies back-pressure: ready stays high and every write with valid high is taken at that clock edge. Until an arm write sets the configured flag, the cell presents its power-up state: the register output reads 1, the auxiliary output reads 0 and the bus floats. Cells chain into ripple adders by feeding one cell's auxiliary output into the next cell's carry input.

Top module: `lut_logic_cell`

## Requirements
- R1: While the cell is not armed (after reset, or after a write of 0 to slot 3), out_x reads 1, out_y reads 0 and bus_out floats, whatever the clock and operand inputs do.
- R2: Armed with all mode bits 0, the table index is {in_x, in_y, in_z} with in_x as the most significant bit. out_x is bit [index] of table 0 and out_y is bit [index] of table 1, both combinational.
- R3: With mode bit 1 (fuse) set, out_x is bit [index] of table 1 when in_w is 1 and bit [index] of table 0 when in_w is 0. out_y still shows table 1.
- R4: With mode bit 0 (product) set, the most significant index bit is in_x AND in_w instead of in_x.
- R5: With mode bit 5 (carry select) set, the least significant index bit is carry_in instead of in_z.
- R6: With mode bit 2 (registered) set, out_x shows the flip-flop, which loads the combinational main result on each rising clock edge while armed.
- R7: While sr_n is low, the flip-flop is forced at once, with no clock edge, to 1 if mode bit 3 is set and to 0 otherwise.
- R8: With mode bit 4 (feedback) set, the middle index bit is the flip-flop output instead of in_y, so a cell with tables 0x66/0x88 toggles on each edge with carry_in high.
- R9: bus_out equals out_x when oe is 1 and the cell is armed; otherwise it is high impedance.
- R10: cfg_ready is always 1. A write with cfg_valid high goes to slot cfg_addr: 0 loads table 0, 1 loads table 1, 2 loads the mode bits from cfg_data[5:0], and 3 loads the armed flag from cfg_data[0]. A write takes effect in the cycle after its clock edge.
- R11: Cells set up with tables 0x96/0xE8 and carry select, chained out_y to carry_in, form a ripple adder whose out_x bits and final out_y give a+b+cin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| rst_n | input | 1 | Active-low reset of the configuration store |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Configuration write accepted (always 1) |
| cfg_addr | input | 2 | Configuration slot |
| cfg_data | input | LUT_SZ | Configuration write data |
| in_w | input | 1 | Operand W: AND partner and fused-table select |
| in_x | input | 1 | Operand X: most significant table index bit |
| in_y | input | 1 | Operand Y: middle table index bit |
| in_z | input | 1 | Operand Z: least significant table index bit |
| carry_in | input | 1 | Carry from the previous cell |
| sr_n | input | 1 | Asynchronous set/reset of the flip-flop, active low |
| oe | input | 1 | Bus output enable |
| out_x | output | 1 | Main result, combinational or registered |
| out_y | output | 1 | Second table result (carry out) |
| bus_out | output | 1 | Tri-statable copy of out_x |

## Verification
The bench walks every index of random table pairs in both the split and the fused arrangement, so a swapped index bit or an inverted fuse select shows up as a wrong bit on a specific vector. It pulses the set/reset line between clock edges with both polarities of the set/reset mode bit. A synchronous implementation or a hard-wired reset value would leave the register output unchanged. It deconfigures a running cell while the clock keeps toggling, which catches a cell that keeps loading its flip-flop or drives the bus before it is armed. A counter built on the feedback path and a four-cell ripple adder expose any mistake in the carry steering or the feedback selection as a wrong count or sum.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;
  parameter int unsigned LUT_IN_DEF = 3;

  // mode word, least significant member listed last
  typedef struct packed {
    logic cin_sel;  // bit 5: carry_in replaces in_z
    logic fb_sel;   // bit 4: flip-flop replaces in_y
    logic sr_set;   // bit 3: set/reset line sets instead of clears
    logic reg_out;  // bit 2: main output from flip-flop
    logic fuse;     // bit 1: two tables act as one 4-input table
    logic and_en;   // bit 0: in_x gated by in_w
  } cell_mode_t;

  localparam int unsigned MODE_W = $bits(cell_mode_t);

  typedef enum logic [1:0] {
    SLOT_TAB0 = 2'd0,
    SLOT_TAB1 = 2'd1,
    SLOT_MODE = 2'd2,
    SLOT_ARM  = 2'd3
  } cfg_slot_e;
endpackage

// File: rtl/lcell_cfg_store.sv
`timescale 1ns/1ps
module lcell_cfg_store
  import lcell_pkg::*;
#(
  parameter int unsigned LUT_SZ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [1:0]        cfg_addr,
  input  logic [LUT_SZ-1:0] cfg_data,
  output logic [LUT_SZ-1:0] tab0,
  output logic [LUT_SZ-1:0] tab1,
  output cell_mode_t        mode,
  output logic              armed
);
  logic take;

  // the store never stalls a write
  assign cfg_ready = 1'b1;
  assign take      = cfg_valid & cfg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab0  <= '0;
      tab1  <= '0;
      mode  <= '0;
      armed <= 1'b0;
    end else if (take) begin
      case (cfg_slot_e'(cfg_addr))
        SLOT_TAB0: tab0  <= cfg_data;
        SLOT_TAB1: tab1  <= cfg_data;
        SLOT_MODE: mode  <= cell_mode_t'(cfg_data[MODE_W-1:0]);
        SLOT_ARM:  armed <= cfg_data[0];
        default:   armed <= armed;
      endcase
    end
  end

  AST_TAB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_addr == 2'd0) |=> (tab0 == $past(cfg_data))); // R10

  AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_addr == 2'd3) |=> (armed == $past(cfg_data[0]))); // R10
endmodule

// File: rtl/lcell_lut_core.sv
`timescale 1ns/1ps
module lcell_lut_core #(
  parameter int unsigned LUT_IN = 3
) (
  input  logic                   in_w,
  input  logic                   in_x,
  input  logic                   in_y,
  input  logic                   in_z,
  input  logic                   carry_in,
  input  logic                   q_fb,
  input  logic                   and_en,
  input  logic                   fb_sel,
  input  logic                   cin_sel,
  input  logic                   fuse,
  input  logic [(1<<LUT_IN)-1:0] tab0,
  input  logic [(1<<LUT_IN)-1:0] tab1,
  output logic                   f_main,
  output logic                   f_aux
);
  localparam int unsigned LUT_SZ = 1 << LUT_IN;
  localparam int unsigned NTAB   = 2;

  logic              sel_hi, sel_mid, sel_lo;
  logic [LUT_IN-1:0] idx;
  logic [LUT_SZ-1:0] tabs [NTAB];
  logic [NTAB-1:0]   f_tab;

  // operand steering in front of the tables
  always_comb begin
    sel_hi  = and_en  ? (in_x & in_w) : in_x;
    sel_mid = fb_sel  ? q_fb          : in_y;
    sel_lo  = cin_sel ? carry_in      : in_z;
    idx     = '0;
    idx[2:0] = {sel_hi, sel_mid, sel_lo};
  end

  assign tabs[0] = tab0;
  assign tabs[1] = tab1;

  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    assign f_tab[g] = tabs[g][idx];
  end

  // fused mode: in_w is the fourth input selecting the table
  assign f_main = fuse ? (in_w ? f_tab[1] : f_tab[0]) : f_tab[0];
  assign f_aux  = f_tab[1];
endmodule

// File: rtl/lcell_ff.sv
`timescale 1ns/1ps
module lcell_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic en,
  input  logic sr_n,
  input  logic sr_val,
  output logic q_raw,
  output logic q_vis
);
  // unarmed: register held at 1 and presented as 1
  always_ff @(posedge clk or negedge sr_n) begin
    if (!sr_n)      q_raw <= sr_val;
    else if (!en)   q_raw <= 1'b1;
    else            q_raw <= d;
  end

  assign q_vis = en ? q_raw : 1'b1;

  AST_PRECFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en) && sr_n && $past(sr_n)) |-> q_raw); // R1

  AST_SR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_n && $past(!sr_n)) |-> (q_raw == $past(sr_val))); // R7
endmodule

// File: rtl/lut_logic_cell.sv
`timescale 1ns/1ps
module lut_logic_cell
  import lcell_pkg::*;
#(
  parameter int unsigned LUT_IN = LUT_IN_DEF,
  localparam int unsigned LUT_SZ = 1 << LUT_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [1:0]        cfg_addr,
  input  logic [LUT_SZ-1:0] cfg_data,
  input  logic              in_w,
  input  logic              in_x,
  input  logic              in_y,
  input  logic              in_z,
  input  logic              carry_in,
  input  logic              sr_n,
  input  logic              oe,
  output logic              out_x,
  output logic              out_y,
  output logic              bus_out
);
  logic [LUT_SZ-1:0] tab0, tab1;
  cell_mode_t        mode;
  logic              armed;
  logic              f_main, f_aux;
  logic              q_raw, q_vis;

  lcell_cfg_store #(.LUT_SZ(LUT_SZ)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .tab0     (tab0),
    .tab1     (tab1),
    .mode     (mode),
    .armed    (armed)
  );

  lcell_lut_core #(.LUT_IN(LUT_IN)) u_core (
    .in_w    (in_w),
    .in_x    (in_x),
    .in_y    (in_y),
    .in_z    (in_z),
    .carry_in(carry_in),
    .q_fb    (q_raw),
    .and_en  (mode.and_en),
    .fb_sel  (mode.fb_sel),
    .cin_sel (mode.cin_sel),
    .fuse    (mode.fuse),
    .tab0    (tab0),
    .tab1    (tab1),
    .f_main  (f_main),
    .f_aux   (f_aux)
  );

  lcell_ff u_ff (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (f_main),
    .en    (armed),
    .sr_n  (sr_n),
    .sr_val(mode.sr_set),
    .q_raw (q_raw),
    .q_vis (q_vis)
  );

  // unarmed cell shows its power-up register value on out_x
  assign out_x   = (mode.reg_out || !armed) ? q_vis : f_main;
  assign out_y   = armed & f_aux;
  assign bus_out = (oe && armed) ? out_x : 1'bz;

  AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode.reg_out && sr_n && $past(armed && sr_n && mode.reg_out))
      |-> (out_x == $past(f_main))); // R6
endmodule

// File: tb/sim_lut_logic_cell.sv
`timescale 1ns/1ps
module sim_lut_logic_cell;
  localparam int LSZ = 8;
  localparam int NB  = 4;

  typedef struct {
    logic        ex, ey, eb, er;
    logic [NB:0] es;
    bit          use_s;
    int          rq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [LSZ-1:0] cfg_data = '0;
  logic in_w = 0, in_x = 0, in_y = 0, in_z = 0, carry_in = 0, sr_n = 0, oe = 0;
  logic cfg_ready, out_x, out_y, bus_out;

  logic [NB-1:0] add_a = '0, add_b = '0;
  logic add_c0 = 1'b0;
  logic [NB-1:0] ax, ay, ardy, abus, acin;

  always #2 clk = ~clk;

  lut_logic_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_w(in_w), .in_x(in_x),
    .in_y(in_y), .in_z(in_z), .carry_in(carry_in), .sr_n(sr_n), .oe(oe),
    .out_x(out_x), .out_y(out_y), .bus_out(bus_out)
  );

  // ripple adder chain sharing the configuration port (R11)
  for (genvar i = 0; i < NB; i++) begin : g_add
    if (i == 0) begin : g_first
      assign acin[i] = add_c0;
    end else begin : g_next
      assign acin[i] = ay[i-1];
    end
    lut_logic_cell u_add (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(ardy[i]),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_w(1'b0), .in_x(add_a[i]),
      .in_y(add_b[i]), .in_z(1'b0), .carry_in(acin[i]), .sr_n(rst_n), .oe(1'b1),
      .out_x(ax[i]), .out_y(ay[i]), .bus_out(abus[i])
    );
  end

  exp_t sbq[$];
  int n_chk = 0, n_fail = 0;

  // bench model state
  logic [7:0] m_t0 = '0, m_t1 = '0;
  logic [5:0] m_mode = '0;
  logic m_arm = 1'b0, q_m = 1'b0, q_pend = 1'b0;
  bit pc_v = 0;
  logic [1:0] pc_a = '0;
  logic [7:0] pc_d = '0;

  // operand values for the next cycle
  logic g_w = 0, g_x = 0, g_y = 0, g_z = 0, g_c = 0, g_sr = 0, g_oe = 0;
  logic [NB-1:0] g_a = '0, g_b = '0;
  logic g_c0 = 0;

  localparam logic [7:0] M_AND = 8'h01, M_FUSE = 8'h02, M_REG = 8'h04,
                         M_SET = 8'h08, M_FB = 8'h10, M_CIN = 8'h20;

  task automatic cycle(input bit dc, input logic [1:0] ca, input logic [7:0] cd,
                       input bit chk, input int rq, input bit use_s);
    exp_t e;
    logic p, b, c, fa, fb, m, ox;
    logic [2:0] idx;
    @(posedge clk);
    q_m = q_pend;
    if (pc_v) begin
      case (pc_a)
        2'd0: m_t0 = pc_d;
        2'd1: m_t1 = pc_d;
        2'd2: m_mode = pc_d[5:0];
        default: m_arm = pc_d[0];
      endcase
    end
    #1;
    pc_v = dc; pc_a = ca; pc_d = cd;
    cfg_valid = dc; cfg_addr = ca; cfg_data = cd;
    in_w = g_w; in_x = g_x; in_y = g_y; in_z = g_z; carry_in = g_c;
    sr_n = g_sr; oe = g_oe;
    add_a = g_a; add_b = g_b; add_c0 = g_c0;
    if (!g_sr) q_m = m_mode[3];
    p = m_mode[0] ? (g_x & g_w) : g_x;
    b = m_mode[4] ? q_m : g_y;
    c = m_mode[5] ? g_c : g_z;
    idx = {p, b, c};
    fa = m_t0[idx];
    fb = m_t1[idx];
    m = m_mode[1] ? (g_w ? fb : fa) : fa;
    ox = !m_arm ? 1'b1 : (m_mode[2] ? q_m : m);
    e.ex = ox;
    e.ey = m_arm ? fb : 1'b0;
    e.eb = (m_arm && g_oe) ? ox : 1'bz;
    e.er = 1'b1;
    e.es = (NB+1)'(g_a) + (NB+1)'(g_b) + (NB+1)'(g_c0);
    e.use_s = use_s;
    e.rq = rq;
    q_pend = !g_sr ? m_mode[3] : (!m_arm ? 1'b1 : m);
    if (chk) sbq.push_back(e);
  endtask

  task automatic wcfg(input logic [1:0] a, input logic [7:0] d);
    cycle(1'b1, a, d, 1'b0, 0, 1'b0);
  endtask

  task automatic setup(input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] md);
    wcfg(2'd0, t0);
    wcfg(2'd1, t1);
    wcfg(2'd2, md);
    wcfg(2'd3, 8'h01);
  endtask

  task automatic rnd_ops();
    g_w = 1'($urandom); g_x = 1'($urandom); g_y = 1'($urandom);
    g_z = 1'($urandom); g_c = 1'($urandom);
  endtask

  // monitor: pops one expectation per cycle, between clock edges
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_chk++;
        if (out_x !== e.ex || out_y !== e.ey || bus_out !== e.eb || cfg_ready !== e.er) begin
          n_fail++;
          $display("FAIL R%0d: x y bus ready = %b %b %b %b, expected %b %b %b %b",
                   e.rq, out_x, out_y, bus_out, cfg_ready, e.ex, e.ey, e.eb, e.er);
        end
        if (e.use_s && ({ay[NB-1], ax} !== e.es)) begin
          n_fail++;
          $display("FAIL R%0d: adder sum = %0d, expected %0d", e.rq, {ay[NB-1], ax}, e.es);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb;
    // reset with the set/reset line low
    g_sr = 0;
    repeat (3) cycle(1'b0, 2'd0, 8'h00, 1'b0, 0, 1'b0);
    rst_n = 1'b1;
    g_sr = 1; g_oe = 1;
    cycle(1'b0, 2'd0, 8'h00, 1'b0, 0, 1'b0);
    // R1: unarmed after reset, clock running
    for (int i = 0; i < 4; i++) begin
      rnd_ops();
      cycle(1'b0, 2'd0, 8'h00, 1'b1, 1, 1'b0);
    end

    // R2 / R9: split tables, exhaustive index walk
    for (int k = 0; k < 3; k++) begin
      ra = 8'($urandom); rb = 8'($urandom);
      setup(ra, rb, 8'h00);
      for (int v = 0; v < 8; v++) begin
        g_x = v[2]; g_y = v[1]; g_z = v[0]; g_w = 1'($urandom); g_c = 1'($urandom);
        g_oe = 1'(v % 3 != 0);
        cycle(1'b0, 2'd0, 8'h00, 1'b1, 2, 1'b0); // R2 R9
      end
    end

    // R3: fused 4-input table
    for (int k = 0; k < 2; k++) begin
      ra = 8'($urandom); rb = 8'($urandom);
      setup(ra, rb, M_FUSE);
      for (int v = 0; v < 16; v++) begin
        g_w = v[3]; g_x = v[2]; g_y = v[1]; g_z = v[0]; g_oe = 1;
        cycle(1'b0, 2'd0, 8'h00, 1'b1, 3, 1'b0); // R3
      end
    end

    // R4 / R5: product full adder with carry steering
    setup(8'h96, 8'hE8, M_AND | M_CIN);
    for (int v = 0; v < 16; v++) begin
      g_w = v[3]; g_x = v[2]; g_y = v[1]; g_c = v[0]; g_z = 1'($urandom);
      cycle(1'b0, 2'd0, 8'h00, 1'b1, 4, 1'b0); // R4 R5
    end

    // R10: rewrite table 0 while checking; old contents apply this cycle
    g_x = 0; g_y = 0; g_z = 0; g_w = 0;
    cycle(1'b1, 2'd0, 8'h01, 1'b1, 10, 1'b0); // R10
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 10, 1'b0); // R10

    // R6 / R9: registered output
    ra = 8'($urandom); rb = 8'($urandom);
    setup(ra, rb, M_REG);
    for (int i = 0; i < 24; i++) begin
      rnd_ops(); g_oe = 1'($urandom);
      cycle(1'b0, 2'd0, 8'h00, 1'b1, 6, 1'b0); // R6 R9
    end

    // R7: asynchronous clear, then asynchronous set
    setup(8'hFF, 8'h00, M_REG);
    g_oe = 1;
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 7, 1'b0);
    g_sr = 0;
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 7, 1'b0); // R7 clear
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 7, 1'b0);
    g_sr = 1;
    setup(8'h00, 8'h00, M_REG | M_SET);
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 7, 1'b0);
    g_sr = 0;
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 7, 1'b0); // R7 set
    g_sr = 1;
    cycle(1'b0, 2'd0, 8'h00, 1'b1, 7, 1'b0);

    // R8: counter bit through feedback
    setup(8'h66, 8'h88, M_REG | M_FB | M_CIN);
    for (int i = 0; i < 16; i++) begin
      rnd_ops(); g_c = 1'(i < 8 ? 1 : $urandom);
      cycle(1'b0, 2'd0, 8'h00, 1'b1, 8, 1'b0); // R8
    end

    // R1: disarm a running cell, clock keeps running
    wcfg(2'd3, 8'h00);
    g_oe = 1;
    for (int i = 0; i < 4; i++) begin
      rnd_ops();
      cycle(1'b0, 2'd0, 8'h00, 1'b1, 1, 1'b0); // R1
    end

    // R11: four-cell ripple adder
    setup(8'h96, 8'hE8, M_CIN);
    for (int i = 0; i < 20; i++) begin
      g_a = NB'($urandom); g_b = NB'($urandom); g_c0 = 1'($urandom);
      if (i == 0) begin g_a = '1; g_b = '1; g_c0 = 1; end
      rnd_ops();
      cycle(1'b0, 2'd0, 8'h00, 1'b1, 11, 1'b1); // R11
    end

    repeat (3) @(posedge clk);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule